// File: doc/BRIEF.md
# Typed Property Register Decoder

This block is an AXI4-Lite slave that turns single-word bus reads and writes into accesses to a fixed map of software-visible properties. Each property has an access type, a bit width, a length (a run of consecutive word addresses whose elements share one definition) and per-element reset values. Depending on its type, a property is a constant, a status word sampled from user logic, a stored control word driven back to user logic, a bus-only loopback word, a handshaked port toward user logic (FIFO-like), or an element-indexed port toward user logic (RAM-like).

Stored properties keep their value inside the block. External read types raise a one-cycle read strobe toward user logic and hold the bus read response until user logic reports valid data. Indexed types also present the element index within the property. External write types raise a one-cycle write strobe together with the width-masked data, and the strobe may be used alone as a start pulse. Accesses to unmapped words, writes to read-only types and reads of write-only types end in an error response with no side effect.

The default map, in word addresses: 0 constant (16 bit), 1 status (12 bit), 2 handshaked read (32 bit), 3-6 indexed read (4 x 16 bit), 7 handshaked write (8 bit), 8-11 indexed write (4 x 32 bit), 12 loopback (32 bit), 13-14 control (2 x 8 bit), 15 handshaked read-write (24 bit), 16-19 indexed read-write (4 x 16 bit).

Top module: `prop_regs`

## Requirements
- R1: With the default byte addressing, word address = bus address divided by 4 (the two low bits are ignored); with BYTE_ADDR=0 each bus address increment selects the next word.
- R2: Word 0 is a constant that always reads 0x0000A5C3 with OKAY (00); a write to it gets SLVERR (10) and leaves the read value unchanged.
- R3: Word 1 reads the 12-bit status input zero-extended, OKAY.
- R4: Word 12 is a loopback word: it resets to 0x12345678, keeps the last written value and reads it back, and changes on no other access.
- R5: Words 13 and 14 are 8-bit control elements resetting to 0x11 and 0x22; a write stores the low 8 bits (upper bits ignored, read back as zero); ctrl_value_o carries element 0 in bits [7:0] and element 1 in bits [15:8] continuously.
- R6: A read of a handshaked or indexed read type raises that property's rd_en for exactly one cycle, the cycle after the read address is accepted; RVALID stays low until user logic asserts rd_valid (which may coincide with rd_en) and then returns its rd_data zero-extended, OKAY.
- R7: Indexed read types present on rd_addr the element index (word minus the property's first word) while rd_en is high.
- R8: A write to a handshaked or indexed write type raises that property's wr_en for exactly one cycle, in the cycle BVALID first rises, with wr_data equal to the bus data's low property-width bits and, for indexed types, wr_addr equal to the element index; BRESP is OKAY.
- R9: A read or write of an unmapped word (20 and above by default) returns SLVERR, read data 0, and raises no strobe.
- R10: Writes to read-only types and reads of write-only types return SLVERR, read data 0, and raise no strobe.
- R11: One transaction is in flight at a time; a write is accepted only when AW and W are both valid, in the same cycle; when a read and a write are presented together the write is taken first and the read afterwards.
- R12: BVALID/BRESP and RVALID/RDATA/RRESP hold steady until the matching ready is seen.
- R13: After reset BVALID, RVALID and every strobe are low and stored properties hold their defaults.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_awaddr | input | 12 | Write address |
| s_awvalid | input | 1 | Write address valid |
| s_awready | output | 1 | Write address ready |
| s_wdata | input | 32 | Write data |
| s_wvalid | input | 1 | Write data valid |
| s_wready | output | 1 | Write data ready |
| s_bresp | output | 2 | Write response (00 OKAY, 10 SLVERR) |
| s_bvalid | output | 1 | Write response valid |
| s_bready | input | 1 | Write response ready |
| s_araddr | input | 12 | Read address |
| s_arvalid | input | 1 | Read address valid |
| s_arready | output | 1 | Read address ready |
| s_rdata | output | 32 | Read data |
| s_rresp | output | 2 | Read response (00 OKAY, 10 SLVERR) |
| s_rvalid | output | 1 | Read data valid |
| s_rready | input | 1 | Read data ready |
| status_i | input | 12 | Status word read at word 1 |
| rdhs_rd_en_o | output | 1 | Handshaked read strobe (word 2) |
| rdhs_rd_data_i | input | 32 | Handshaked read data |
| rdhs_rd_valid_i | input | 1 | Handshaked read data valid |
| rdidx_rd_en_o | output | 1 | Indexed read strobe (words 3-6) |
| rdidx_rd_addr_o | output | 2 | Indexed read element |
| rdidx_rd_data_i | input | 16 | Indexed read data |
| rdidx_rd_valid_i | input | 1 | Indexed read data valid |
| wrhs_wr_en_o | output | 1 | Handshaked write strobe (word 7) |
| wrhs_wr_data_o | output | 8 | Handshaked write data |
| wridx_wr_en_o | output | 1 | Indexed write strobe (words 8-11) |
| wridx_wr_addr_o | output | 2 | Indexed write element |
| wridx_wr_data_o | output | 32 | Indexed write data |
| ctrl_value_o | output | 16 | Stored control elements (words 13-14) |
| rwhs_rd_en_o | output | 1 | Read-write handshaked read strobe (word 15) |
| rwhs_rd_data_i | input | 24 | Read-write handshaked read data |
| rwhs_rd_valid_i | input | 1 | Read-write handshaked read data valid |
| rwhs_wr_en_o | output | 1 | Read-write handshaked write strobe |
| rwhs_wr_data_o | output | 24 | Read-write handshaked write data |
| rwidx_rd_en_o | output | 1 | Read-write indexed read strobe (words 16-19) |
| rwidx_rd_addr_o | output | 2 | Read-write indexed read element |
| rwidx_rd_data_i | input | 16 | Read-write indexed read data |
| rwidx_rd_valid_i | input | 1 | Read-write indexed read data valid |
| rwidx_wr_en_o | output | 1 | Read-write indexed write strobe |
| rwidx_wr_addr_o | output | 2 | Read-write indexed write element |
| rwidx_wr_data_o | output | 16 | Read-write indexed write data |

## Verification
A bus read and a bus write can be requested in the same cycle, and the block must serve them one after the other without dropping either. The bench raises AWVALID, WVALID and ARVALID at the same clock edge, both aimed at the loopback word, and checks that only the write handshake is offered in that cycle. It then lets the read complete and judges the order from the read data: it must already hold the value the competing write carried.

// File: rtl/prop_map_pkg.sv
package prop_map_pkg;

    typedef enum logic [3:0] {
        K_CONST, K_STATUS, K_RD_HS, K_RD_IDX, K_WR_HS,
        K_WR_IDX, K_LOOPBACK, K_CTRL, K_RW_HS, K_RW_IDX
    } prop_kind_e;

    localparam int NPROP  = 10;
    localparam int MAX_W  = 32;
    localparam int PIDX_W = $clog2(NPROP);

    localparam int P_CONST  = 0;
    localparam int P_STATUS = 1;
    localparam int P_RD_HS  = 2;
    localparam int P_RD_IDX = 3;
    localparam int P_WR_HS  = 4;
    localparam int P_WR_IDX = 5;
    localparam int P_LOOP   = 6;
    localparam int P_CTRL   = 7;
    localparam int P_RW_HS  = 8;
    localparam int P_RW_IDX = 9;

    localparam prop_kind_e PROP_KIND [NPROP] = '{
        K_CONST, K_STATUS, K_RD_HS, K_RD_IDX, K_WR_HS,
        K_WR_IDX, K_LOOPBACK, K_CTRL, K_RW_HS, K_RW_IDX
    };
    localparam int PROP_LEN   [NPROP] = '{1, 1, 1, 4, 1, 4, 1, 2, 1, 4};
    localparam int PROP_WIDTH [NPROP] = '{16, 12, 32, 16, 8, 32, 32, 8, 24, 16};

    // first word of each property: running sum of the lengths
    function automatic int base_of(int p);
        int b = 0;
        for (int i = 0; i < p; i++) b += PROP_LEN[i];
        return b;
    endfunction

    function automatic int max_len();
        int m = 1;
        for (int i = 0; i < NPROP; i++) if (PROP_LEN[i] > m) m = PROP_LEN[i];
        return m;
    endfunction

    localparam int ELEM_W = (max_len() > 1) ? $clog2(max_len()) : 1;

    function automatic prop_kind_e kind_of(logic [PIDX_W-1:0] p);
        for (int i = 0; i < NPROP; i++) if (int'(p) == i) return PROP_KIND[i];
        return K_CONST;
    endfunction

    function automatic int width_of(logic [PIDX_W-1:0] p);
        for (int i = 0; i < NPROP; i++) if (int'(p) == i) return PROP_WIDTH[i];
        return MAX_W;
    endfunction

    function automatic logic [MAX_W-1:0] width_mask(int w);
        logic [MAX_W:0] t;
        t = (MAX_W+1)'(1) << w;
        t = t - 1'b1;
        return t[MAX_W-1:0];
    endfunction

    function automatic logic [MAX_W-1:0] prop_default(int p, int e);
        case (p)
            P_CONST: return 32'h0000_A5C3;
            P_LOOP:  return 32'h1234_5678;
            P_CTRL:  return (e == 0) ? 32'h11 : 32'h22;
            default: return '0;
        endcase
    endfunction

    function automatic logic is_readable(prop_kind_e k);
        return !(k inside {K_WR_HS, K_WR_IDX});
    endfunction

    function automatic logic is_writable(prop_kind_e k);
        return k inside {K_WR_HS, K_WR_IDX, K_LOOPBACK, K_CTRL, K_RW_HS, K_RW_IDX};
    endfunction

    function automatic logic is_ext_read(prop_kind_e k);
        return k inside {K_RD_HS, K_RD_IDX, K_RW_HS, K_RW_IDX};
    endfunction

    function automatic logic is_stored(prop_kind_e k);
        return k inside {K_LOOPBACK, K_CTRL};
    endfunction

endpackage

// File: rtl/prop_decode.sv
module prop_decode
    import prop_map_pkg::*;
#(
    parameter int ADDR_W    = 12,
    parameter int DATA_W    = 32,
    parameter bit BYTE_ADDR = 1'b1
) (
    input  logic [ADDR_W-1:0] addr_i,
    output logic              hit_o,
    output logic [PIDX_W-1:0] prop_o,
    output logic [ELEM_W-1:0] elem_o
);
    localparam int LSB = BYTE_ADDR ? $clog2(DATA_W/8) : 0;

    logic [ADDR_W-1:0] word;
    assign word = addr_i >> LSB;

    always_comb begin
        hit_o  = 1'b0;
        prop_o = '0;
        elem_o = '0;
        for (int p = 0; p < NPROP; p++) begin
            if (int'(word) >= base_of(p) && int'(word) < base_of(p) + PROP_LEN[p]) begin
                hit_o  = 1'b1;
                prop_o = PIDX_W'(p);
                elem_o = ELEM_W'(int'(word) - base_of(p));
            end
        end
    end
endmodule

// File: rtl/prop_store.sv
module prop_store
    import prop_map_pkg::*;
#(
    parameter int W_LOOP   = PROP_WIDTH[P_LOOP],
    parameter int W_CTRL   = PROP_WIDTH[P_CTRL],
    parameter int CTRL_LEN = PROP_LEN[P_CTRL]
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             we_i,
    input  logic [PIDX_W-1:0]                prop_i,
    input  logic [ELEM_W-1:0]                elem_i,
    input  logic [MAX_W-1:0]                 wdata_i,
    output logic [W_LOOP-1:0]                loop_o,
    output logic [CTRL_LEN-1:0][W_CTRL-1:0]  ctrl_o
);
    logic [W_LOOP-1:0] loop_d, loop_q;
    logic [CTRL_LEN-1:0][W_CTRL-1:0] ctrl_d, ctrl_q;

    always_comb begin
        loop_d = loop_q;
        ctrl_d = ctrl_q;
        if (we_i && int'(prop_i) == P_LOOP) loop_d = W_LOOP'(wdata_i);
        for (int e = 0; e < CTRL_LEN; e++)
            if (we_i && int'(prop_i) == P_CTRL && int'(elem_i) == e)
                ctrl_d[e] = W_CTRL'(wdata_i);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            loop_q <= W_LOOP'(prop_default(P_LOOP, 0));
            for (int e = 0; e < CTRL_LEN; e++) ctrl_q[e] <= W_CTRL'(prop_default(P_CTRL, e));
        end else begin
            loop_q <= loop_d;
            ctrl_q <= ctrl_d;
        end
    end

    assign loop_o = loop_q;
    assign ctrl_o = ctrl_q;

    // R4: loopback word moves only on a write aimed at it
    a_r4_loop_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(we_i && int'(prop_i) == P_LOOP) |=> $stable(loop_q));
    // R5: a control element moves only on a write aimed at the control property
    a_r5_ctrl_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(we_i && int'(prop_i) == P_CTRL) |=> $stable(ctrl_q));
endmodule

// File: rtl/prop_regs.sv
module prop_regs
    import prop_map_pkg::*;
#(
    parameter int ADDR_W    = 12,
    parameter int DATA_W    = 32,
    parameter bit BYTE_ADDR = 1'b1
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic [ADDR_W-1:0]                  s_awaddr,
    input  logic                               s_awvalid,
    output logic                               s_awready,
    input  logic [DATA_W-1:0]                  s_wdata,
    input  logic                               s_wvalid,
    output logic                               s_wready,
    output logic [1:0]                         s_bresp,
    output logic                               s_bvalid,
    input  logic                               s_bready,
    input  logic [ADDR_W-1:0]                  s_araddr,
    input  logic                               s_arvalid,
    output logic                               s_arready,
    output logic [DATA_W-1:0]                  s_rdata,
    output logic [1:0]                         s_rresp,
    output logic                               s_rvalid,
    input  logic                               s_rready,
    input  logic [PROP_WIDTH[P_STATUS]-1:0]    status_i,
    output logic                               rdhs_rd_en_o,
    input  logic [PROP_WIDTH[P_RD_HS]-1:0]     rdhs_rd_data_i,
    input  logic                               rdhs_rd_valid_i,
    output logic                               rdidx_rd_en_o,
    output logic [ELEM_W-1:0]                  rdidx_rd_addr_o,
    input  logic [PROP_WIDTH[P_RD_IDX]-1:0]    rdidx_rd_data_i,
    input  logic                               rdidx_rd_valid_i,
    output logic                               wrhs_wr_en_o,
    output logic [PROP_WIDTH[P_WR_HS]-1:0]     wrhs_wr_data_o,
    output logic                               wridx_wr_en_o,
    output logic [ELEM_W-1:0]                  wridx_wr_addr_o,
    output logic [PROP_WIDTH[P_WR_IDX]-1:0]    wridx_wr_data_o,
    output logic [PROP_LEN[P_CTRL]*PROP_WIDTH[P_CTRL]-1:0] ctrl_value_o,
    output logic                               rwhs_rd_en_o,
    input  logic [PROP_WIDTH[P_RW_HS]-1:0]     rwhs_rd_data_i,
    input  logic                               rwhs_rd_valid_i,
    output logic                               rwhs_wr_en_o,
    output logic [PROP_WIDTH[P_RW_HS]-1:0]     rwhs_wr_data_o,
    output logic                               rwidx_rd_en_o,
    output logic [ELEM_W-1:0]                  rwidx_rd_addr_o,
    input  logic [PROP_WIDTH[P_RW_IDX]-1:0]    rwidx_rd_data_i,
    input  logic                               rwidx_rd_valid_i,
    output logic                               rwidx_wr_en_o,
    output logic [ELEM_W-1:0]                  rwidx_wr_addr_o,
    output logic [PROP_WIDTH[P_RW_IDX]-1:0]    rwidx_wr_data_o
);
    localparam int W_LOOP   = PROP_WIDTH[P_LOOP];
    localparam int W_CTRL   = PROP_WIDTH[P_CTRL];
    localparam int CTRL_LEN = PROP_LEN[P_CTRL];
    localparam logic [1:0] RESP_OK  = 2'b00;
    localparam logic [1:0] RESP_ERR = 2'b10;

    typedef enum logic [1:0] {S_IDLE, S_BRESP, S_WAIT, S_RRESP} bus_st_e;

    typedef struct packed {
        bus_st_e            st;
        logic [1:0]         bresp;
        logic [1:0]         rresp;
        logic [DATA_W-1:0]  rdata;
        logic [PIDX_W-1:0]  pend;
        logic [NPROP-1:0]   rd_en;
        logic [NPROP-1:0]   wr_en;
        logic [ELEM_W-1:0]  rd_addr;
        logic [ELEM_W-1:0]  wr_addr;
        logic [MAX_W-1:0]   wr_data;
    } regs_t;

    regs_t d, q;

    // address decoders for both channels
    logic              wr_hit, rd_hit;
    logic [PIDX_W-1:0] wr_prop, rd_prop;
    logic [ELEM_W-1:0] wr_elem, rd_elem;

    prop_decode #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BYTE_ADDR(BYTE_ADDR)) i_wr_dec (
        .addr_i(s_awaddr), .hit_o(wr_hit), .prop_o(wr_prop), .elem_o(wr_elem));
    prop_decode #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BYTE_ADDR(BYTE_ADDR)) i_rd_dec (
        .addr_i(s_araddr), .hit_o(rd_hit), .prop_o(rd_prop), .elem_o(rd_elem));

    // stored properties
    logic                            store_we;
    logic [W_LOOP-1:0]               loop_val;
    logic [CTRL_LEN-1:0][W_CTRL-1:0] ctrl_val;

    prop_store i_store (
        .clk(clk), .rst_n(rst_n), .we_i(store_we), .prop_i(wr_prop), .elem_i(wr_elem),
        .wdata_i(s_wdata[MAX_W-1:0]), .loop_o(loop_val), .ctrl_o(ctrl_val));

    // user read returns gathered per property
    logic [NPROP-1:0]            ext_vld;
    logic [NPROP-1:0][MAX_W-1:0] ext_dat;

    always_comb begin
        ext_vld = '0;
        ext_dat = '0;
        ext_vld[P_RD_HS]  = rdhs_rd_valid_i;   ext_dat[P_RD_HS]  = MAX_W'(rdhs_rd_data_i);
        ext_vld[P_RD_IDX] = rdidx_rd_valid_i;  ext_dat[P_RD_IDX] = MAX_W'(rdidx_rd_data_i);
        ext_vld[P_RW_HS]  = rwhs_rd_valid_i;   ext_dat[P_RW_HS]  = MAX_W'(rwhs_rd_data_i);
        ext_vld[P_RW_IDX] = rwidx_rd_valid_i;  ext_dat[P_RW_IDX] = MAX_W'(rwidx_rd_data_i);
    end

    // values answered without user handshake
    logic [MAX_W-1:0] direct_val;
    always_comb begin
        direct_val = '0;
        case (kind_of(rd_prop))
            K_CONST:    direct_val = width_mask(width_of(rd_prop)) &
                                     prop_default(int'(rd_prop), int'(rd_elem));
            K_STATUS:   direct_val = MAX_W'(status_i);
            K_LOOPBACK: direct_val = MAX_W'(loop_val);
            K_CTRL: begin
                for (int e = 0; e < CTRL_LEN; e++)
                    if (int'(rd_elem) == e) direct_val = MAX_W'(ctrl_val[e]);
            end
            default: ;
        endcase
    end

    logic aw_take, ar_take;
    assign aw_take = (q.st == S_IDLE) && s_awvalid && s_wvalid;
    assign ar_take = (q.st == S_IDLE) && s_arvalid && !(s_awvalid && s_wvalid);

    always_comb begin
        d       = q;
        d.rd_en = '0;
        d.wr_en = '0;
        store_we = 1'b0;
        case (q.st)
            S_IDLE: begin
                if (aw_take) begin
                    d.st = S_BRESP;
                    if (wr_hit && is_writable(kind_of(wr_prop))) begin
                        d.bresp = RESP_OK;
                        if (is_stored(kind_of(wr_prop))) begin
                            store_we = 1'b1;
                        end else begin
                            d.wr_en[wr_prop] = 1'b1;
                            d.wr_addr        = wr_elem;
                            d.wr_data        = s_wdata[MAX_W-1:0] & width_mask(width_of(wr_prop));
                        end
                    end else begin
                        d.bresp = RESP_ERR;
                    end
                end else if (ar_take) begin
                    if (!rd_hit || !is_readable(kind_of(rd_prop))) begin
                        d.st    = S_RRESP;
                        d.rresp = RESP_ERR;
                        d.rdata = '0;
                    end else if (is_ext_read(kind_of(rd_prop))) begin
                        d.st             = S_WAIT;
                        d.pend           = rd_prop;
                        d.rd_en[rd_prop] = 1'b1;
                        d.rd_addr        = rd_elem;
                    end else begin
                        d.st    = S_RRESP;
                        d.rresp = RESP_OK;
                        d.rdata = DATA_W'(direct_val);
                    end
                end
            end
            S_BRESP: if (s_bready) d.st = S_IDLE;
            S_WAIT: begin
                if (ext_vld[q.pend]) begin
                    d.st    = S_RRESP;
                    d.rresp = RESP_OK;
                    d.rdata = DATA_W'(ext_dat[q.pend] & width_mask(width_of(q.pend)));
                end
            end
            S_RRESP: if (s_rready) d.st = S_IDLE;
            default: d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign s_awready = aw_take;
    assign s_wready  = aw_take;
    assign s_arready = ar_take;
    assign s_bvalid  = (q.st == S_BRESP);
    assign s_bresp   = q.bresp;
    assign s_rvalid  = (q.st == S_RRESP);
    assign s_rresp   = q.rresp;
    assign s_rdata   = q.rdata;

    assign rdhs_rd_en_o    = q.rd_en[P_RD_HS];
    assign rdidx_rd_en_o   = q.rd_en[P_RD_IDX];
    assign rdidx_rd_addr_o = q.rd_addr;
    assign rwhs_rd_en_o    = q.rd_en[P_RW_HS];
    assign rwidx_rd_en_o   = q.rd_en[P_RW_IDX];
    assign rwidx_rd_addr_o = q.rd_addr;

    assign wrhs_wr_en_o    = q.wr_en[P_WR_HS];
    assign wrhs_wr_data_o  = q.wr_data[PROP_WIDTH[P_WR_HS]-1:0];
    assign wridx_wr_en_o   = q.wr_en[P_WR_IDX];
    assign wridx_wr_addr_o = q.wr_addr;
    assign wridx_wr_data_o = q.wr_data[PROP_WIDTH[P_WR_IDX]-1:0];
    assign rwhs_wr_en_o    = q.wr_en[P_RW_HS];
    assign rwhs_wr_data_o  = q.wr_data[PROP_WIDTH[P_RW_HS]-1:0];
    assign rwidx_wr_en_o   = q.wr_en[P_RW_IDX];
    assign rwidx_wr_addr_o = q.wr_addr;
    assign rwidx_wr_data_o = q.wr_data[PROP_WIDTH[P_RW_IDX]-1:0];

    assign ctrl_value_o = ctrl_val;

    // R12: responses hold until accepted
    a_r12_bresp_hold: assert property (@(posedge clk) disable iff (!rst_n)
        s_bvalid && !s_bready |=> s_bvalid && $stable(s_bresp));
    a_r12_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
        s_rvalid && !s_rready |=> s_rvalid && $stable(s_rdata) && $stable(s_rresp));
    // R9/R10: an error read carries zero data
    a_r9_err_zero: assert property (@(posedge clk) disable iff (!rst_n)
        s_rvalid && s_rresp == RESP_ERR |-> s_rdata == '0);
    // R6: read strobe is one-hot and lasts one cycle, response not yet valid
    a_r6_rd_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        q.rd_en != '0 |-> $onehot0(q.rd_en) && !s_rvalid ##1 q.rd_en == '0);
    // R8: write strobe lasts one cycle and coincides with the write response
    a_r8_wr_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        q.wr_en != '0 |-> s_bvalid && $onehot0(q.wr_en) ##1 q.wr_en == '0);
    // R11: never both channels handshaken in the same cycle
    a_r11_one_txn: assert property (@(posedge clk) disable iff (!rst_n)
        !(s_awready && s_arready));
endmodule

// File: tb/test_prop_regs.sv
module test_prop_regs;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    logic [11:0] s_awaddr = '0, s_araddr = '0;
    logic        s_awvalid = 0, s_wvalid = 0, s_bready = 1, s_arvalid = 0, s_rready = 1;
    logic [31:0] s_wdata = '0;
    logic        s_awready, s_wready, s_bvalid, s_arready, s_rvalid;
    logic [1:0]  s_bresp, s_rresp;
    logic [31:0] s_rdata;
    logic [11:0] status_i = '0;
    logic        rdhs_rd_en, rdidx_rd_en, wrhs_wr_en, wridx_wr_en;
    logic        rwhs_rd_en, rwhs_wr_en, rwidx_rd_en, rwidx_wr_en;
    logic [31:0] rdhs_rd_data = '0;
    logic        rdhs_rd_valid = 0, rdidx_rd_valid = 0, rwhs_rd_valid = 0, rwidx_rd_valid = 0;
    logic [15:0] rdidx_rd_data = '0, rwidx_rd_data = '0;
    logic [23:0] rwhs_rd_data = '0;
    logic [1:0]  rdidx_rd_addr, wridx_wr_addr, rwidx_rd_addr, rwidx_wr_addr;
    logic [7:0]  wrhs_wr_data;
    logic [31:0] wridx_wr_data;
    logic [15:0] ctrl_value, rwidx_wr_data;
    logic [23:0] rwhs_wr_data;

    prop_regs i_prop_regs (
        .clk(clk), .rst_n(rst_n),
        .s_awaddr(s_awaddr), .s_awvalid(s_awvalid), .s_awready(s_awready),
        .s_wdata(s_wdata), .s_wvalid(s_wvalid), .s_wready(s_wready),
        .s_bresp(s_bresp), .s_bvalid(s_bvalid), .s_bready(s_bready),
        .s_araddr(s_araddr), .s_arvalid(s_arvalid), .s_arready(s_arready),
        .s_rdata(s_rdata), .s_rresp(s_rresp), .s_rvalid(s_rvalid), .s_rready(s_rready),
        .status_i(status_i),
        .rdhs_rd_en_o(rdhs_rd_en), .rdhs_rd_data_i(rdhs_rd_data), .rdhs_rd_valid_i(rdhs_rd_valid),
        .rdidx_rd_en_o(rdidx_rd_en), .rdidx_rd_addr_o(rdidx_rd_addr),
        .rdidx_rd_data_i(rdidx_rd_data), .rdidx_rd_valid_i(rdidx_rd_valid),
        .wrhs_wr_en_o(wrhs_wr_en), .wrhs_wr_data_o(wrhs_wr_data),
        .wridx_wr_en_o(wridx_wr_en), .wridx_wr_addr_o(wridx_wr_addr), .wridx_wr_data_o(wridx_wr_data),
        .ctrl_value_o(ctrl_value),
        .rwhs_rd_en_o(rwhs_rd_en), .rwhs_rd_data_i(rwhs_rd_data), .rwhs_rd_valid_i(rwhs_rd_valid),
        .rwhs_wr_en_o(rwhs_wr_en), .rwhs_wr_data_o(rwhs_wr_data),
        .rwidx_rd_en_o(rwidx_rd_en), .rwidx_rd_addr_o(rwidx_rd_addr),
        .rwidx_rd_data_i(rwidx_rd_data), .rwidx_rd_valid_i(rwidx_rd_valid),
        .rwidx_wr_en_o(rwidx_wr_en), .rwidx_wr_addr_o(rwidx_wr_addr), .rwidx_wr_data_o(rwidx_wr_data));

    int n_chk = 0, n_fail = 0;

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    // strobe monitor: bit order rdhs,rdidx,rwhs,rwidx reads then wrhs,wridx,rwhs,rwidx writes
    logic [7:0] en_vec, en_prev = '0;
    assign en_vec = {rwidx_wr_en, rwhs_wr_en, wridx_wr_en, wrhs_wr_en,
                     rwidx_rd_en, rwhs_rd_en, rdidx_rd_en, rdhs_rd_en};
    int n_pulse = 0, n_long = 0;
    always @(negedge clk) begin
        n_pulse += $countones(en_vec);
        if ((en_vec & en_prev) != 0) n_long++;
        en_prev <= en_vec;
    end

    logic [7:0]  snap_en;
    logic [31:0] snap_d;
    logic [1:0]  snap_a;

    task automatic axi_write(input logic [11:0] a, input logic [31:0] v, output logic [1:0] resp);
        @(negedge clk);
        s_awaddr = a; s_wdata = v; s_awvalid = 1; s_wvalid = 1;
        #1;
        while (!s_awready) begin @(negedge clk); #1; end
        @(posedge clk);
        @(negedge clk);
        s_awvalid = 0; s_wvalid = 0;
        while (!s_bvalid) @(negedge clk);
        resp = s_bresp;
        snap_en = en_vec;
        case (1'b1)
            wrhs_wr_en:  begin snap_d = 32'(wrhs_wr_data);  snap_a = 2'd0; end
            wridx_wr_en: begin snap_d = wridx_wr_data;      snap_a = wridx_wr_addr; end
            rwhs_wr_en:  begin snap_d = 32'(rwhs_wr_data);  snap_a = 2'd0; end
            rwidx_wr_en: begin snap_d = 32'(rwidx_wr_data); snap_a = rwidx_wr_addr; end
            default:     begin snap_d = '0; snap_a = 2'd0; end
        endcase
        @(negedge clk);
    endtask

    task automatic axi_read(input logic [11:0] a, output logic [31:0] v, output logic [1:0] resp);
        @(negedge clk);
        s_araddr = a; s_arvalid = 1;
        #1;
        while (!s_arready) begin @(negedge clk); #1; end
        @(posedge clk);
        @(negedge clk);
        s_arvalid = 0;
        while (!s_rvalid) @(negedge clk);
        v = s_rdata; resp = s_rresp;
        @(negedge clk);
    endtask

    // which: 0 rdhs, 1 rdidx, 2 rwhs, 3 rwidx
    task automatic ext_read(input logic [11:0] a, input int which, input logic [31:0] dat,
                            input int dly, input logic [1:0] exp_idx, input logic [31:0] exp_v);
        @(negedge clk);
        s_araddr = a; s_arvalid = 1;
        #1;
        while (!s_arready) begin @(negedge clk); #1; end
        @(posedge clk);
        @(negedge clk);
        s_arvalid = 0;
        check("R6 rd_en strobe of the addressed property", 32'(en_vec), 32'(1 << which));
        if (which == 1) check("R7 rd_addr element index", 32'(rdidx_rd_addr), 32'(exp_idx));
        if (which == 3) check("R7 rd_addr element index", 32'(rwidx_rd_addr), 32'(exp_idx));
        for (int i = 0; i < dly; i++) begin
            check("R6 no RVALID before rd_valid", 32'(s_rvalid), 0);
            @(negedge clk);
        end
        check("R6 no RVALID before rd_valid", 32'(s_rvalid), 0);
        case (which)
            0: begin rdhs_rd_valid = 1; rdhs_rd_data = dat; end
            1: begin rdidx_rd_valid = 1; rdidx_rd_data = dat[15:0]; end
            2: begin rwhs_rd_valid = 1; rwhs_rd_data = dat[23:0]; end
            default: begin rwidx_rd_valid = 1; rwidx_rd_data = dat[15:0]; end
        endcase
        @(negedge clk);
        rdhs_rd_valid = 0; rdidx_rd_valid = 0; rwhs_rd_valid = 0; rwidx_rd_valid = 0;
        check("R6 RVALID after rd_valid", 32'(s_rvalid), 1);
        check("R6 read data from user logic", s_rdata, exp_v);
        check("R6 read response OKAY", 32'(s_rresp), 0);
        @(negedge clk);
    endtask

    typedef struct packed {
        logic        wr;
        logic [11:0] addr;
        logic [31:0] wdata;
        logic [1:0]  resp;
        logic [31:0] rdata;
    } vec_t;

    localparam int NVEC = 17;
    localparam vec_t VECS [NVEC] = '{
        '{1'b0, 12'h000, 32'h0,         2'b00, 32'h0000_A5C3},  // R2 constant
        '{1'b1, 12'h000, 32'hFFFF_FFFF, 2'b10, 32'h0},          // R2 write to constant
        '{1'b0, 12'h003, 32'h0,         2'b00, 32'h0000_A5C3},  // R1 low bits ignored, R2 unchanged
        '{1'b0, 12'h004, 32'h0,         2'b00, 32'h0000_0ABC},  // R3 status
        '{1'b0, 12'h030, 32'h0,         2'b00, 32'h1234_5678},  // R4 default
        '{1'b1, 12'h030, 32'hCAFE_F00D, 2'b00, 32'h0},          // R4 write
        '{1'b0, 12'h030, 32'h0,         2'b00, 32'hCAFE_F00D},  // R4 readback
        '{1'b0, 12'h034, 32'h0,         2'b00, 32'h0000_0011},  // R5 default e0
        '{1'b0, 12'h038, 32'h0,         2'b00, 32'h0000_0022},  // R5 default e1
        '{1'b1, 12'h038, 32'hFFFF_FF5A, 2'b00, 32'h0},          // R5 write e1
        '{1'b0, 12'h038, 32'h0,         2'b00, 32'h0000_005A},  // R5 upper bits dropped
        '{1'b0, 12'h050, 32'h0,         2'b10, 32'h0},          // R9 unmapped read
        '{1'b1, 12'h050, 32'h1,         2'b10, 32'h0},          // R9 unmapped write
        '{1'b0, 12'h01C, 32'h0,         2'b10, 32'h0},          // R10 read write-only
        '{1'b0, 12'h024, 32'h0,         2'b10, 32'h0},          // R10 read write-only indexed
        '{1'b1, 12'h004, 32'h5,         2'b10, 32'h0},          // R10 write status
        '{1'b1, 12'h008, 32'h5,         2'b10, 32'h0}           // R10 write read-only handshaked
    };

    logic [31:0] rv;
    logic [1:0]  rr;

    initial begin
        // watchdog
        repeat (20000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual 0x%08h expected 0x%08h", 1, 0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        check("R13 BVALID after reset", 32'(s_bvalid), 0);
        check("R13 RVALID after reset", 32'(s_rvalid), 0);
        check("R13 strobes after reset", 32'(en_vec), 0);
        check("R13 control defaults", 32'(ctrl_value), 32'h2211);

        status_i = 12'hABC;
        for (int i = 0; i < NVEC; i++) begin
            if (VECS[i].wr) begin
                axi_write(VECS[i].addr, VECS[i].wdata, rr);
                check($sformatf("R2/R4/R5/R9/R10 vector %0d BRESP", i), 32'(rr), 32'(VECS[i].resp));
            end else begin
                axi_read(VECS[i].addr, rv, rr);
                check($sformatf("R1/R2/R3/R4/R5/R9/R10 vector %0d RRESP", i), 32'(rr), 32'(VECS[i].resp));
                check($sformatf("R1/R2/R3/R4/R5/R9/R10 vector %0d RDATA", i), rv, VECS[i].rdata);
            end
        end
        check("R5 ctrl_value_o after write", 32'(ctrl_value), 32'h5A11);
        check("R9 R10 no strobe on error or stored access", 32'(n_pulse), 0);

        // R8 writes to external types
        axi_write(12'h01C, 32'h1234_56A7, rr);
        check("R8 handshaked write BRESP", 32'(rr), 0);
        check("R8 handshaked write strobe", 32'(snap_en), 32'h10);
        check("R8 handshaked write data masked", snap_d, 32'hA7);
        axi_write(12'h028, 32'h89AB_CDEF, rr);
        check("R8 indexed write strobe", 32'(snap_en), 32'h20);
        check("R8 indexed write element", 32'(snap_a), 2);
        check("R8 indexed write data", snap_d, 32'h89AB_CDEF);
        axi_write(12'h03C, 32'hFF12_3456, rr);
        check("R8 rw handshaked write strobe", 32'(snap_en), 32'h40);
        check("R8 rw handshaked write data masked", snap_d, 32'h0012_3456);
        axi_write(12'h04C, 32'hFFFF_1357, rr);
        check("R8 rw indexed write strobe", 32'(snap_en), 32'h80);
        check("R8 rw indexed write element", 32'(snap_a), 3);
        check("R8 rw indexed write data masked", snap_d, 32'h1357);
        check("R8 four write strobes", 32'(n_pulse), 4);

        // R6 / R7 external reads
        ext_read(12'h008, 0, 32'h0BAD_F00D, 3, 2'd0, 32'h0BAD_F00D);
        ext_read(12'h014, 1, 32'h0000_4321, 0, 2'd2, 32'h0000_4321);
        ext_read(12'h03C, 2, 32'h00AB_CDEF, 2, 2'd0, 32'h00AB_CDEF);
        ext_read(12'h044, 3, 32'h0000_BEEF, 1, 2'd1, 32'h0000_BEEF);
        check("R6 R8 every strobe one cycle wide", 32'(n_long), 0);
        check("R6 eight strobes in total", 32'(n_pulse), 8);

        // R12 read response held while RREADY low
        @(negedge clk);
        s_rready = 0;
        s_araddr = 12'h034; s_arvalid = 1;
        @(negedge clk);
        s_arvalid = 0;
        for (int i = 0; i < 3; i++) begin
            check("R12 RVALID held", 32'(s_rvalid), 1);
            check("R12 RDATA held", s_rdata, 32'h11);
            @(negedge clk);
        end
        s_rready = 1;
        @(negedge clk);
        check("R12 RVALID drops after RREADY", 32'(s_rvalid), 0);

        // R12 write response held while BREADY low
        s_bready = 0;
        s_awaddr = 12'h030; s_wdata = 32'h5555_AAAA; s_awvalid = 1; s_wvalid = 1;
        @(negedge clk);
        s_awvalid = 0; s_wvalid = 0;
        for (int i = 0; i < 3; i++) begin
            check("R12 BVALID held", 32'(s_bvalid), 1);
            @(negedge clk);
        end
        s_bready = 1;
        @(negedge clk);
        check("R12 BVALID drops after BREADY", 32'(s_bvalid), 0);

        // R11 write and read in the same cycle: write first
        s_awaddr = 12'h030; s_wdata = 32'h0F0F_0F0F; s_awvalid = 1; s_wvalid = 1;
        s_araddr = 12'h030; s_arvalid = 1;
        #1;
        check("R11 AWREADY with both pending", 32'(s_awready), 1);
        check("R11 ARREADY held off", 32'(s_arready), 0);
        @(negedge clk);
        s_awvalid = 0; s_wvalid = 0;
        #1;
        check("R11 no read accept during write response", 32'(s_arready), 0);
        while (!s_arready) begin @(negedge clk); #1; end
        @(posedge clk);
        @(negedge clk);
        s_arvalid = 0;
        while (!s_rvalid) @(negedge clk);
        check("R11 read returns the competing write", s_rdata, 32'h0F0F_0F0F);
        @(negedge clk);

        // R4 other accesses leave loopback alone
        axi_read(12'h030, rv, rr);
        check("R4 loopback kept after other traffic", rv, 32'h0F0F_0F0F);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule